// File: doc/BRIEF.md
# Paged Address Translator with Stretched CPU Clock

This block sits between a small CPU whose memory accesses each complete in one CPU clock cycle and main memory. It generates the CPU clock itself from a faster base clock. Each CPU cycle, it looks the virtual page of the address up in a fully associative table. On a hit it replaces the page number with a physical page number and passes the byte offset through unchanged. It also stretches the high phase of the CPU clock by the number of base clocks that the target memory's speed class needs.

On a miss nothing is aborted. The CPU clock is held high while the block raises a request carrying the missing virtual page. An external loader agent answers with the physical page and speed class. The entry is installed at that clock edge, the lookup is repeated on the next base clock and hits, and the CPU sees only a long cycle. Writes into a configurable video window always take one long cycle of fixed length, and later accesses return to the rate of their own speed class. Once the table is full, new fills replace entries in round-robin order.

Top module: `page_xlate`

## Requirements
- R1: After reset the CPU clock, the memory enable and the miss request are low, and every table entry is invalid, so the first access to any page misses.
- R2: On a hit, the physical address is the entry's physical page concatenated with the unchanged low OFF_W offset bits. The memory enable, the entry's speed class and the CPU write flag are presented from the base clock after the lookup until the end of the CPU low phase, and they stay stable during the stretch.
- R3: On a miss, the miss request rises one base clock after the lookup with the virtual page (address bits above OFF_W) and stays high until the loader's fill pulse. The memory enable stays low for the whole stall.
- R4: The fill is accepted on the edge where the fill strobe is high during a stall. The lookup repeats on the next base clock and hits. The CPU clock stays high throughout, so a miss answered D base clocks after the request shows 3+D+E high base clocks.
- R5: A CPU cycle is a high phase of 1+E base clocks followed by exactly one low base clock. E is 0, 1, 3 or 7 for speed class 0, 1, 2 or 3.
- R6: A write whose virtual page lies in [VID_LO, VID_HI] uses E = VID_EXTRA whatever its class. A read of the same page, or a write elsewhere, uses its class value.
- R7: A fill goes into the lowest-numbered invalid entry. When all entries are valid, fills replace entries 0, 1, 2, ... in turn, starting from entry 0.
- R8: A fill strobe outside a stall changes no table entry.
- R9: At most one table entry matches any virtual page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | Virtual address, held by the CPU for the whole CPU cycle |
| cpu_we | input | 1 | CPU write flag |
| cpu_clk | output | 1 | Generated CPU clock (high phase stretched or frozen) |
| phys_addr | output | ADDR_W | Translated physical address |
| mem_en | output | 1 | Memory access enable |
| mem_class | output | 2 | Speed class of the addressed page |
| mem_we | output | 1 | Memory write flag |
| miss_req | output | 1 | Translation miss request to the loader |
| miss_vpage | output | ADDR_W-OFF_W | Virtual page that missed |
| fill_valid | input | 1 | Loader fill strobe (one base clock) |
| fill_ppage | input | ADDR_W-OFF_W | Physical page for the fill |
| fill_speed | input | 2 | Speed class for the fill |

## Verification
Every result is counted in base clocks from the lookup clock, the first high base clock of a CPU cycle. The miss request is due one clock later. A hit's address, enable and class are due on the next clock and stay valid until the CPU clock falls. The CPU clock falls after 1+E high clocks on a hit and after 3+D+E on a miss. The bench drives inputs and samples outputs on falling base-clock edges. It counts high samples of the CPU clock until the low phase, then checks the translated outputs in that low sample. So each timing claim turns into an exact count, compared with a value computed from the speed class, the video rule and the fill delay.

// File: rtl/pt_pkg.sv
package pt_pkg;

  typedef enum logic [1:0] {
    S_LOW  = 2'd0,
    S_LOOK = 2'd1,
    S_MISS = 2'd2,
    S_STR  = 2'd3
  } seq_t;

  // extra base clocks of high phase per speed class
  function automatic logic [3:0] class_extra(input logic [1:0] cls);
    case (cls)
      2'd0:    return 4'd0;
      2'd1:    return 4'd1;
      2'd2:    return 4'd3;
      default: return 4'd7;
    endcase
  endfunction

endpackage

// File: rtl/pt_cam.sv
module pt_cam #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 16,
  parameter int PPN_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [VPN_W-1:0]           lk_vpn,
  output logic                       lk_hit,
  output logic [PPN_W-1:0]           lk_ppn,
  output logic [1:0]                 lk_cls,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic [VPN_W-1:0]           wr_vpn,
  input  logic [PPN_W-1:0]           wr_ppn,
  input  logic [1:0]                 wr_cls,
  output logic [ENTRIES-1:0]         valid_vec
);
  localparam int DATA_W = PPN_W + 2;

  logic [VPN_W-1:0]  tag_mem  [ENTRIES];
  logic [DATA_W-1:0] data_mem [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] hit_vec;
  logic [DATA_W-1:0]  sel_data;

  // payload storage: no reset, single write port
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_vpn;
      data_mem[wr_idx] <= {wr_ppn, wr_cls};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = valid_q[g] && (tag_mem[g] == lk_vpn);
    end
  endgenerate

  always_comb begin
    sel_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) sel_data = sel_data | data_mem[i];
    end
  end

  assign lk_hit    = |hit_vec;
  assign lk_ppn    = sel_data[DATA_W-1:2];
  assign lk_cls    = sel_data[1:0];
  assign valid_vec = valid_q;

  // R9: a virtual page never matches two entries
  p_single_match_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R7: a written entry is valid afterwards
  p_write_sets_valid_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_vec[$past(wr_idx)]);

endmodule

// File: rtl/pt_victim.sv
module pt_victim #(
  parameter int ENTRIES = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ENTRIES-1:0]         valid_vec,
  input  logic                       commit,
  output logic [$clog2(ENTRIES)-1:0] idx
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             all_valid;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
  end

  assign all_valid = &valid_vec;
  assign idx       = all_valid ? rr_q : free_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (commit && all_valid) begin
      if (rr_q == IDX_W'(ENTRIES - 1)) rr_q <= '0;
      else                             rr_q <= rr_q + 1'b1;
    end
  end

  // R7: while a free slot exists, the chosen slot is free
  p_pick_free_r7: assert property (@(posedge clk) disable iff (rst)
    !all_valid |-> !valid_vec[idx]);

endmodule

// File: rtl/pt_seq.sv
module pt_seq
  import pt_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int OFF_W     = 8,
  parameter int CNT_W     = 4,
  parameter int VID_LO    = 'hE0,
  parameter int VID_HI    = 'hFF,
  parameter int VID_EXTRA = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic                    cpu_we,
  output logic [ADDR_W-OFF_W-1:0] lk_vpn,
  input  logic                    lk_hit,
  input  logic [ADDR_W-OFF_W-1:0] lk_ppn,
  input  logic [1:0]              lk_cls,
  input  logic                    fill_valid,
  output logic                    fill_commit,
  output logic                    cpu_clk,
  output logic [ADDR_W-1:0]       phys_addr,
  output logic                    mem_en,
  output logic [1:0]              mem_class,
  output logic                    mem_we,
  output logic                    miss_req,
  output logic [ADDR_W-OFF_W-1:0] miss_vpage
);
  localparam int VPN_W = ADDR_W - OFF_W;
  localparam logic [VPN_W-1:0] VLO = VPN_W'(VID_LO);
  localparam logic [VPN_W-1:0] VHI = VPN_W'(VID_HI);

  seq_t             st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] extra;
  logic             in_video;

  assign lk_vpn      = cpu_addr[ADDR_W-1:OFF_W];
  assign in_video    = (lk_vpn >= VLO) && (lk_vpn <= VHI);
  assign extra       = (in_video && cpu_we) ? CNT_W'(VID_EXTRA)
                                            : CNT_W'(class_extra(lk_cls));
  assign fill_commit = (st_q == S_MISS) && fill_valid;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_LOW:  st_d = S_LOOK;
      S_LOOK: begin
        if (!lk_hit)          st_d = S_MISS;
        else if (extra != '0) st_d = S_STR;
        else                  st_d = S_LOW;
      end
      S_MISS: if (fill_valid) st_d = S_LOOK;
      S_STR:  if (cnt_q == CNT_W'(1)) st_d = S_LOW;
      default: st_d = S_LOW;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_LOW;
      cnt_q      <= '0;
      cpu_clk    <= 1'b0;
      miss_req   <= 1'b0;
      miss_vpage <= '0;
      phys_addr  <= '0;
      mem_en     <= 1'b0;
      mem_class  <= 2'd0;
      mem_we     <= 1'b0;
    end else begin
      st_q     <= st_d;
      cpu_clk  <= (st_d != S_LOW);
      miss_req <= (st_d == S_MISS);
      if (st_q == S_LOOK && lk_hit) begin
        phys_addr <= {lk_ppn, cpu_addr[OFF_W-1:0]};
        mem_en    <= 1'b1;
        mem_class <= lk_cls;
        mem_we    <= cpu_we;
        cnt_q     <= extra;
      end else if (st_q == S_LOW) begin
        mem_en <= 1'b0;
      end
      if (st_q == S_STR) cnt_q <= cnt_q - 1'b1;
      if (st_q == S_LOOK && !lk_hit) miss_vpage <= lk_vpn;
    end
  end

  // R3: request held until the loader answers
  p_miss_held_r3: assert property (@(posedge clk) disable iff (rst)
    (miss_req && !fill_valid) |=> miss_req);

  // R3: no memory access while stalled
  p_no_access_in_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_MISS) |-> !mem_en);

  // R4: the CPU clock stays high during the stall
  p_clock_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_MISS) |-> cpu_clk);

  // R4: a fill releases the stall into a fresh lookup that hits
  p_release_r4: assert property (@(posedge clk) disable iff (rst)
    fill_commit |=> (st_q == S_LOOK) && lk_hit);

  // R2: address stable while the stretch runs
  p_addr_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_STR && $past(st_q) == S_STR) |-> $stable(phys_addr));

  // R5: the low phase lasts exactly one base clock
  p_one_low_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_LOW) |=> cpu_clk);

endmodule

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int ADDR_W    = 24,
  parameter int OFF_W     = 8,
  parameter int ENTRIES   = 16,
  parameter int CNT_W     = 4,
  parameter int VID_LO    = 'hE0,
  parameter int VID_HI    = 'hFF,
  parameter int VID_EXTRA = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic                    cpu_we,
  output logic                    cpu_clk,
  output logic [ADDR_W-1:0]       phys_addr,
  output logic                    mem_en,
  output logic [1:0]              mem_class,
  output logic                    mem_we,
  output logic                    miss_req,
  output logic [ADDR_W-OFF_W-1:0] miss_vpage,
  input  logic                    fill_valid,
  input  logic [ADDR_W-OFF_W-1:0] fill_ppage,
  input  logic [1:0]              fill_speed
);
  localparam int PG_W  = ADDR_W - OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [PG_W-1:0]    lk_vpn;
  logic               lk_hit;
  logic [PG_W-1:0]    lk_ppn;
  logic [1:0]         lk_cls;
  logic               fill_commit;
  logic [IDX_W-1:0]   victim_idx;
  logic [ENTRIES-1:0] valid_vec;

  pt_cam #(
    .ENTRIES (ENTRIES),
    .VPN_W   (PG_W),
    .PPN_W   (PG_W)
  ) u_cam (
    .clk       (clk),
    .rst       (rst),
    .lk_vpn    (lk_vpn),
    .lk_hit    (lk_hit),
    .lk_ppn    (lk_ppn),
    .lk_cls    (lk_cls),
    .wr_en     (fill_commit),
    .wr_idx    (victim_idx),
    .wr_vpn    (miss_vpage),
    .wr_ppn    (fill_ppage),
    .wr_cls    (fill_speed),
    .valid_vec (valid_vec)
  );

  pt_victim #(
    .ENTRIES (ENTRIES)
  ) u_victim (
    .clk       (clk),
    .rst       (rst),
    .valid_vec (valid_vec),
    .commit    (fill_commit),
    .idx       (victim_idx)
  );

  pt_seq #(
    .ADDR_W    (ADDR_W),
    .OFF_W     (OFF_W),
    .CNT_W     (CNT_W),
    .VID_LO    (VID_LO),
    .VID_HI    (VID_HI),
    .VID_EXTRA (VID_EXTRA)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .cpu_addr    (cpu_addr),
    .cpu_we      (cpu_we),
    .lk_vpn      (lk_vpn),
    .lk_hit      (lk_hit),
    .lk_ppn      (lk_ppn),
    .lk_cls      (lk_cls),
    .fill_valid  (fill_valid),
    .fill_commit (fill_commit),
    .cpu_clk     (cpu_clk),
    .phys_addr   (phys_addr),
    .mem_en      (mem_en),
    .mem_class   (mem_class),
    .mem_we      (mem_we),
    .miss_req    (miss_req),
    .miss_vpage  (miss_vpage)
  );

endmodule

// File: tb/page_xlate_bench.sv
`timescale 1ns/1ps
module page_xlate_bench;
  localparam int VIDX = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] cpu_addr = '0;
  logic        cpu_we = 1'b0;
  logic        cpu_clk, mem_en, mem_we, miss_req;
  logic [23:0] phys_addr;
  logic [1:0]  mem_class;
  logic [15:0] miss_vpage;
  logic        fill_valid = 1'b0;
  logic [15:0] fill_ppage = '0;
  logic [1:0]  fill_speed = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  page_xlate u_page_xlate (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_clk(cpu_clk), .phys_addr(phys_addr), .mem_en(mem_en),
    .mem_class(mem_class), .mem_we(mem_we), .miss_req(miss_req),
    .miss_vpage(miss_vpage), .fill_valid(fill_valid),
    .fill_ppage(fill_ppage), .fill_speed(fill_speed)
  );

  function automatic [15:0] vp(input int i);
    return 16'(16'h0040 + i * 5);
  endfunction
  function automatic [15:0] pp(input int i);
    return 16'(16'hA000 ^ (i * 257));
  endfunction
  function automatic int ext(input int c);
    case (c)
      0: return 0;
      1: return 1;
      2: return 3;
      default: return 7;
    endcase
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // Entered and left on a falling edge inside the CPU low phase.
  task automatic access(input [15:0] v, input [7:0] off, input bit we,
                        input bit exp_miss, input int dly,
                        input [15:0] fpp, input [1:0] fcls,
                        input [15:0] epp, input [1:0] ecls, input int e,
                        input bit stray, input string rq);
    int highs = 0;
    bit missed = 0;
    cpu_addr = {v, off};
    cpu_we   = we;
    if (stray) begin
      fill_valid = 1'b1;
      fill_ppage = fpp;
      fill_speed = fcls;
    end
    forever begin
      @(negedge clk);
      fill_valid = 1'b0;
      if (!cpu_clk) break;
      highs++;
      if (highs > 100) break;
      if (miss_req && !missed) begin
        missed = 1;
        chk(miss_vpage == v, "R3", "miss page", miss_vpage, v);
        chk(!mem_en, "R3", "enable during stall", mem_en, 0);
        for (int k = 0; k < dly; k++) begin
          @(negedge clk);
          highs++;
          chk(miss_req && cpu_clk, "R3", "request/clock held", miss_req, 1);
        end
        fill_valid = 1'b1;
        fill_ppage = fpp;
        fill_speed = fcls;
        @(negedge clk);
        highs++;
        fill_valid = 1'b0;
        chk(!miss_req, "R4", "request dropped after fill", miss_req, 0);
      end
    end
    chk(missed == exp_miss, exp_miss ? "R3" : "R2", "miss seen", missed, exp_miss);
    chk(highs == (exp_miss ? 3 + dly + e : 1 + e), exp_miss ? "R4" : "R5",
        "high base clocks", highs, exp_miss ? 3 + dly + e : 1 + e);
    chk(phys_addr == {epp, off}, "R2", "phys addr", phys_addr, {epp, off});
    chk(mem_en && mem_class == ecls && mem_we == we, "R2", "enable/class/we",
        {mem_en, mem_class, mem_we}, {1'b1, ecls, we});
    if (rq != "") chk(1'b1, rq, "scenario", 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cpu_addr = {vp(0), 8'h00};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(!cpu_clk && !mem_en && !miss_req, "R1", "reset outputs",
        {cpu_clk, mem_en, miss_req}, 0);

    // R1, R7: first fills miss and take entries 0..15 in order
    for (int i = 0; i < 16; i++)
      access(vp(i), 8'(i * 17), i[0], 1, i % 4, pp(i), 2'(i % 4),
             pp(i), 2'(i % 4), ext(i % 4), 0, "R1");

    // R2, R5: sweep hits over every entry and class
    for (int i = 0; i < 16; i++)
      access(vp(i), 8'(255 - i), 0, 0, 0, 0, 0, pp(i), 2'(i % 4),
             ext(i % 4), 0, "R5");

    // R7: table full, round robin from entry 0
    access(vp(16), 8'h33, 0, 1, 2, pp(16), 2'd2, pp(16), 2'd2, 3, 0, "R7");
    access(vp(1), 8'h01, 0, 0, 0, 0, 0, pp(1), 2'd1, 1, 0, "R7");
    access(vp(0), 8'h44, 0, 1, 0, 16'h1234, 2'd3, 16'h1234, 2'd3, 7, 0, "R7");
    access(vp(1), 8'h55, 0, 1, 1, 16'h2345, 2'd0, 16'h2345, 2'd0, 0, 0, "R7");
    access(vp(3), 8'h66, 0, 0, 0, 0, 0, pp(3), 2'd3, 7, 0, "R7");

    // R6: video write slow, read and other writes at class rate
    access(16'h00E4, 8'h10, 1, 1, 1, 16'h0BEE, 2'd1, 16'h0BEE, 2'd1, VIDX, 0, "R6");
    access(16'h00E4, 8'h11, 0, 0, 0, 0, 0, 16'h0BEE, 2'd1, 1, 0, "R6");
    access(vp(5), 8'h12, 1, 0, 0, 0, 0, pp(5), 2'd1, 1, 0, "R6");
    access(16'h00E4, 8'h13, 1, 0, 0, 0, 0, 16'h0BEE, 2'd1, VIDX, 0, "R6");

    // R8: stray fill strobe outside a stall changes nothing
    access(vp(4), 8'h20, 0, 0, 0, 16'hDEAD, 2'd3, pp(4), 2'd0, 0, 1, "R8");
    access(16'h00E4, 8'h21, 0, 0, 0, 0, 0, 16'h0BEE, 2'd1, 1, 0, "R8");
    access(vp(4), 8'h22, 0, 0, 0, 0, 0, pp(4), 2'd0, 0, 0, "R8");

    // R7: evicted page misses again, takes next slot
    access(vp(3), 8'h77, 0, 1, 3, 16'h3456, 2'd2, 16'h3456, 2'd2, 3, 0, "R7");
    // R9: the refilled page translates to exactly its new frame
    access(vp(3), 8'h78, 0, 0, 0, 0, 0, 16'h3456, 2'd2, 3, 0, "R9");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule